// File: doc/BRIEF.md
# Averaging PI Current Regulator

This block closes a current loop around a motor driver. A current-sense converter delivers one 12-bit unsigned reading per enable pulse, at 32 pulses per PWM period. The regulator sums a block of readings and turns the block into an average with a shift. It then runs a proportional-integral update against a fixed setpoint of 100 LSB and produces an 8-bit duty value for a PWM compare input.

All arithmetic is signed 32-bit fixed point and wraps in two's complement. The gains are signed inputs scaled by 2^6. The integral gain is applied twice: once when the integrator is updated and again when the integrator term enters the output sum. A synchronous reset restarts the sample block. It leaves the integrator and the duty register as they are, so the loop resumes from its last operating point.

Top module: `avg_pi_regulator`

## Requirements
- R1: Each `sample_valid` pulse increments an 8-bit block count. When the new count is 32 or less, `sample`, zero-extended, is added to a signed 32-bit accumulator.
- R2: On the pulse whose incremented count would exceed 32 (the 33rd pulse after a clear), the sample is discarded and a regulation step runs. The count and the accumulator both return to 0.
- R3: The average is the accumulator shifted arithmetically right by 5. The error is 100 minus that average, computed as a signed 32-bit value.
- R4: The integrator is a signed 32-bit register, updated as integ + error*Ki with 32-bit wraparound.
- R5: The raw output is (error*Kp + integ*Ki) shifted arithmetically right by 6, where integ is the value already updated in the same step.
- R6: A negative raw output gives a duty of 0. A raw output above 255 gives 255. Any other value passes through unchanged.
- R7: `duty` changes only in the clock edge that completes a regulation step. At that edge `duty_update` goes high for exactly one cycle. It is high in the cycle after the 33rd pulse is sampled.
- R8: Synchronous reset clears only the block count and the accumulator. `duty` and the integrator keep their values across reset.
- R9: With Kp = 10 and Ki = 2, starting from a zero integrator and a block of zero samples, the first step gives a duty of 21.
- R10: Clock cycles without `sample_valid` change neither the count, the accumulator, the integrator nor `duty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | One-cycle enable marking a new converter sample |
| sample | input | 12 | Unsigned current-sense sample |
| kp | input | 32 | Signed proportional gain, scaled by 2^6 |
| ki | input | 32 | Signed integral gain, scaled by 2^6 |
| duty | output | 8 | Duty value held for the PWM compare input |
| duty_update | output | 1 | One-cycle strobe when a new duty value is loaded |

## Verification
The assertions assume that `sample_valid` is a single-cycle pulse sampled only on clock edges. They also assume that the gains stay constant within a block. The stimulus therefore changes `kp` and `ki` only right after a completed step or during reset, and it separates pulses with at least one idle cycle. This keeps the idle-cycle checks meaningful. The sample values sweep the full 12-bit range, so the error and the raw output both take large negative and large positive values and reach both saturation limits.

// File: rtl/avg_pi_regulator.sv
module avg_pi_regulator #(
  parameter int SAMPLE_W   = 12,
  parameter int DUTY_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 8,
  parameter int BLOCK_LEN  = 32,
  parameter int GAIN_SHIFT = 6,
  parameter int SETPOINT   = 100
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sample_valid,
  input  logic [SAMPLE_W-1:0]      sample,
  input  logic signed [DATA_W-1:0] kp,
  input  logic signed [DATA_W-1:0] ki,
  output logic [DUTY_W-1:0]        duty,
  output logic                     duty_update
);
  localparam int AVG_SHIFT = $clog2(BLOCK_LEN);
  localparam logic [CNT_W-1:0] BLK = CNT_W'(BLOCK_LEN);
  localparam logic signed [DATA_W-1:0] SETPT = DATA_W'(SETPOINT);
  localparam logic signed [DATA_W-1:0] DMAX = DATA_W'((1 << DUTY_W) - 1);

  logic [CNT_W-1:0]         blk_cnt = '0;
  logic signed [DATA_W-1:0] acc     = '0;
  logic signed [DATA_W-1:0] integ   = '0;
  logic [DUTY_W-1:0]        duty_q  = '0;
  logic                     upd_q   = 1'b0;

  logic [CNT_W-1:0]         cnt_inc;
  logic                     run_step;
  logic signed [DATA_W-1:0] smp_ext, avg, err, integ_nx, p_term, i_term, raw;
  logic [DUTY_W-1:0]        duty_nx;

  assign cnt_inc  = blk_cnt + 1'b1;
  assign run_step = sample_valid && (cnt_inc > BLK);
  assign smp_ext  = {{(DATA_W-SAMPLE_W){1'b0}}, sample};
  assign avg      = acc >>> AVG_SHIFT;
  assign err      = SETPT - avg;
  assign integ_nx = integ + err * ki;
  assign p_term   = err * kp;
  assign i_term   = integ_nx * ki;
  assign raw      = (p_term + i_term) >>> GAIN_SHIFT;
  assign duty_nx  = (raw < 0) ? '0 : (raw > DMAX) ? DMAX[DUTY_W-1:0] : raw[DUTY_W-1:0];

  always_ff @(posedge clk) begin
    upd_q <= 1'b0;
    if (rst) begin
      blk_cnt <= '0;
      acc     <= '0;
    end else if (run_step) begin
      blk_cnt <= '0;
      acc     <= '0;
      integ   <= integ_nx;
      duty_q  <= duty_nx;
      upd_q   <= 1'b1;
    end else if (sample_valid) begin
      blk_cnt <= cnt_inc;
      acc     <= acc + smp_ext;
    end
  end

  assign duty        = duty_q;
  assign duty_update = upd_q;
endmodule

module avg_pi_regulator_chk #(
  parameter int DUTY_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  parameter int BLOCK_LEN = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sample_valid,
  input logic [CNT_W-1:0]         blk_cnt,
  input logic signed [DATA_W-1:0] acc,
  input logic signed [DATA_W-1:0] integ,
  input logic [DUTY_W-1:0]        duty,
  input logic                     duty_update
);
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    blk_cnt <= CNT_W'(BLOCK_LEN));

  a_r2_cleared_after_step: assert property (@(posedge clk) disable iff (rst)
    duty_update |-> (blk_cnt == '0 && acc == '0));

  a_r7_strobe_from_pulse: assert property (@(posedge clk) disable iff (rst)
    duty_update |-> $past(sample_valid));

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
    duty_update |=> !duty_update);

  a_r7_duty_held: assert property (@(posedge clk) disable iff (rst)
    !duty_update |-> $stable(duty));

  a_r4_integ_held: assert property (@(posedge clk) disable iff (rst)
    !duty_update |-> $stable(integ));

  a_r8_reset_clears_block: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (blk_cnt == '0 && acc == '0));

  a_r10_idle_no_change: assert property (@(posedge clk) disable iff (rst)
    (!$past(sample_valid) && !$past(rst)) |-> ($stable(blk_cnt) && $stable(acc)));
endmodule

bind avg_pi_regulator avg_pi_regulator_chk #(
  .DUTY_W(DUTY_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BLOCK_LEN(BLOCK_LEN)
) u_chk (
  .clk(clk), .rst(rst), .sample_valid(sample_valid), .blk_cnt(blk_cnt),
  .acc(acc), .integ(integ), .duty(duty), .duty_update(duty_update)
);

// File: tb/tb_avg_pi_regulator.sv
module tb_avg_pi_regulator;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_valid = 1'b0;
  logic [11:0] sample = '0;
  logic signed [31:0] kp = 32'sd10, ki = 32'sd2;
  logic [7:0] duty;
  logic duty_update;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0, m_acc = 0, m_integ = 0, m_duty = 0;
  bit m_upd = 0;

  always #2.5 clk = ~clk;

  avg_pi_regulator dut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample(sample),
    .kp(kp), .ki(ki), .duty(duty), .duty_update(duty_update)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // model of R1..R6 in plain integer arithmetic
  task automatic model_pulse(int s);
    int avg, err, raw;
    m_cnt++;
    m_upd = 0;
    if (m_cnt > 32) begin
      avg = m_acc >>> 5;
      err = 100 - avg;
      m_integ = m_integ + err * int'(ki);
      raw = (err * int'(kp) + m_integ * int'(ki)) >>> 6;
      m_duty = raw < 0 ? 0 : (raw > 255 ? 255 : raw);
      m_cnt = 0;
      m_acc = 0;
      m_upd = 1;
    end else m_acc += s;
  endtask

  task automatic pulse(int s, string req);
    @(negedge clk);
    sample_valid = 1'b1;
    sample = 12'(s);
    model_pulse(s);
    @(negedge clk);
    sample_valid = 1'b0;
    check({req, " strobe"}, int'(duty_update), int'(m_upd));
    check({req, " duty"}, int'(duty), m_duty);
    @(negedge clk);
    check("R10 idle strobe", int'(duty_update), 0);
    check("R10 idle duty", int'(duty), m_duty);
  endtask

  task automatic block(int base, int stride, string req);
    for (int i = 0; i < 33; i++) pulse((base + i * stride) & 12'hFFF, req);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 reset duty", int'(duty), 0);
    check("R7 reset strobe", int'(duty_update), 0);

    // R9: zero block with default gains
    block(0, 0, "R9");
    check("R9 first duty", int'(duty), 21);

    // R1..R5 over 24 steps with varied sample patterns
    for (int st = 0; st < 24; st++) begin
      block((st * 173) % 260, (st % 7) * 3 - 9, "R5 step");
      check("R3 duty after step", int'(duty), m_duty);
    end

    // R6 upper saturation
    @(negedge clk); kp = 32'sd4000; ki = 32'sd0;
    block(0, 0, "R6 high");
    check("R6 sat high", int'(duty), 255);
    // R6 lower saturation
    @(negedge clk); kp = 32'sd50; ki = 32'sd1;
    block(4095, 0, "R6 low");
    check("R6 sat low", int'(duty), 0);

    // R4 wraparound with large gains
    @(negedge clk); kp = -32'sd70000; ki = 32'sd90000;
    for (int st = 0; st < 4; st++) block(st * 1000, 97, "R4 wrap");

    // R8: reset mid-block keeps duty and integrator
    @(negedge clk); kp = 32'sd10; ki = 32'sd2;
    block(100, 1, "R8 pre");
    for (int i = 0; i < 10; i++) pulse(4000, "R8 partial");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_cnt = 0; m_acc = 0;
    check("R8 duty kept", int'(duty), m_duty);
    check("R8 no strobe", int'(duty_update), 0);
    block(50, 2, "R8 post");
    check("R8 integ kept", int'(duty), m_duty);

    // R2: discarded 33rd sample of any value
    block(3000, 0, "R2");
    check("R2 step result", int'(duty), m_duty);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule